// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an asynchronous serial line into parallel characters. It runs on a system clock and advances only on a receive-clock enable pulse, `rx_tick`. That pulse arrives at one, sixteen or sixty-four times the bit rate. In the oversampled modes a falling line must still read low half a bit later before it counts as a start bit. After that the line is sampled once per bit time. The block collects 5 to 8 data bits, least significant bit first, then an optional odd or even parity bit, then exactly one stop bit. Each finished character goes to a holding register with parity, framing and overrun flags.

A line that stays low through the whole character, including the stop bit, is a break. It produces one all-zero character with the framing flag set. It also raises a break-detect output, which stays high until the line returns to mark. The receiver runs only while its enable is high and the active-low carrier input is low. While the carrier input is high, receive ticks are ignored.

Top module: `async_break_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero: `rx_data`, `rx_ready`, `parity_err`, `frame_err`, `overrun_err` and `break_det`.
- R2: After `rx_enable` goes high, the first qualified tick is ignored and the line is first examined on the second. While `rx_enable` is low the receiver stays idle and drops any partial character, and `rx_ready`, all three error flags and `break_det` are cleared.
- R3: A tick that arrives while `carrier_n` is high has no effect on reception, so a whole frame sent during that time yields no character.
- R4: In 16X and 64X modes, a low sample found during the search is the candidate. The line is sampled again F/2 ticks later, where F is the clock factor. If it is high there, the search resumes and no character is produced.
- R5: Data bit k is sampled F/2 + (k+1)·F ticks after the candidate low sample, LSB first. In 1X mode it is sampled k+1 ticks after that sample. `char_len` selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Unused upper bits of `rx_data` are zero.
- R6: With `parity_on` high, one parity bit follows the data. If `parity_even` is 1 the data bits and the parity bit together hold an even number of ones; if it is 0 they hold an odd number. A mismatch sets `parity_err` when the character is delivered.
- R7: The stop-bit sample delivers the character. `rx_data` and `rx_ready` update one clock after that tick. A one-clock `hold_read` pulse clears `rx_ready`, unless a new character is delivered in the same clock.
- R8: `overrun_err` is set when a character is delivered while `rx_ready` is still high and no `hold_read` comes in that clock.
- R9: A low stop bit that is not part of a break sets `frame_err`. One bit time later the line is checked again. If it is low, that sample is treated as the middle of a start bit, otherwise the search resumes.
- R10: Only the first stop bit is examined. If the data, the parity bit and that stop bit are all low, exactly one all-zero character is delivered with `frame_err` set, and `parity_err` is left as it was. `break_det` rises with that delivery. No new search starts until a tick sees the line high, and that tick also clears `break_det`.
- R11: A one-clock `err_clear` pulse clears `parity_err`, `frame_err` and `overrun_err`. An error raised in the same clock takes priority.
- R12: `clk_factor` selects the oversampling: 00 = 1X, 01 = 16X, 10 and 11 = 64X. In 1X mode the first low sample found during the search is taken as the start bit, with no recheck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | Receive-clock enable pulse, one clock wide |
| rx_line | input | 1 | Serial input, high = mark |
| carrier_n | input | 1 | Active-low carrier present; ticks are ignored while high |
| rx_enable | input | 1 | Receiver enable |
| clk_factor | input | 2 | Oversampling select |
| char_len | input | 2 | Data bits per character (5 to 8) |
| parity_on | input | 1 | Expect a parity bit |
| parity_even | input | 1 | 1 = even parity, 0 = odd |
| hold_read | input | 1 | Holding register read strobe |
| err_clear | input | 1 | Clears the three error flags |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Holding register has an unread character |
| parity_err | output | 1 | Parity mismatch seen |
| frame_err | output | 1 | Stop bit found low |
| overrun_err | output | 1 | Unread character overwritten |
| break_det | output | 1 | Break seen, line not yet back at mark |

## Verification
The embedded properties assume that the mode inputs (`clk_factor`, `char_len`, `parity_on`) stay constant while a character is being assembled. The bit-index bound in the shifter depends on this assumption. The stimulus changes those inputs only while `rx_enable` is low. Each line level is held for a whole number of ticks, so every sample falls well inside a bit cell. `rx_tick` is never high in the same clock as an enable edge.

// File: rtl/async_break_rx_pkg.sv
// Shared types for the break-detecting asynchronous receiver.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package async_break_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

    typedef enum logic [1:0] {
        FAC_1X     = 2'd0,
        FAC_16X    = 2'd1,
        FAC_64X    = 2'd2,
        FAC_64X_B  = 2'd3
    } fac_e;
endpackage

// File: rtl/brk_rx_bitclock.sv
// Down-counter that marks the next sampling tick.
// When loaded with v at a tick, it reports "expired" at the (v+1)-th tick after it.
// Assumes: load has priority over counting; adv is the qualified receive tick.
module brk_rx_bitclock #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down towards zero on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (adv && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/brk_rx_shifter.sv
// Assembles data bits at increasing positions and accumulates their parity and
// whether any of them was one. Unused upper bits stay zero after clr.
// Assumes: len_code stays constant while a character is being assembled.
module brk_rx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    input  logic [1:0]        len_code,
    output logic [DATA_W-1:0] data,
    output logic              last,
    output logic              par_acc,
    output logic              any_one
);
    localparam int MIN_LEN = DATA_W - 3;
    localparam int IDX_W   = $clog2(DATA_W);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] len_m1;

    assign len_m1 = IDX_W'(MIN_LEN - 1) + IDX_W'(len_code);
    assign last   = (idx == len_m1);

    // Place each incoming bit at the current index, tracking parity and ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data    <= '0;
            idx     <= '0;
            par_acc <= 1'b0;
            any_one <= 1'b0;
        end else if (shift) begin
            for (int b = 0; b < DATA_W; b++) begin
                if (idx == IDX_W'(b))
                    data[b] <= bit_in;
            end
            idx     <= idx + 1'b1;
            par_acc <= par_acc ^ bit_in;
            any_one <= any_one | bit_in;
        end
    end

    // R5: data bits never land beyond the selected character length.
    assert_index_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (idx <= len_m1));
endmodule

// File: rtl/brk_rx_status.sv
// Holding register and flags: ready, parity, framing, overrun, break detect.
// Assumes: flush (receiver disabled) and xfer are never high together.
module brk_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              xfer,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_pe,
    input  logic              xfer_fe,
    input  logic              brk_set,
    input  logic              brk_clr,
    input  logic              hold_read,
    input  logic              err_clear,
    output logic [DATA_W-1:0] hold_data,
    output logic              ready,
    output logic              pe,
    output logic              fe,
    output logic              oe,
    output logic              brk
);
    // Capture a delivered character into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_data <= '0;
        else if (xfer)
            hold_data <= xfer_data;
    end

    // Ready: set on delivery, cleared by read or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            ready <= 1'b0;
        else if (xfer)
            ready <= 1'b1;
        else if (hold_read)
            ready <= 1'b0;
    end

    // Error flags: setting wins over clearing in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            pe <= 1'b0;
            fe <= 1'b0;
            oe <= 1'b0;
        end else begin
            if (xfer && xfer_pe)
                pe <= 1'b1;
            else if (err_clear)
                pe <= 1'b0;
            if (xfer && xfer_fe)
                fe <= 1'b1;
            else if (err_clear)
                fe <= 1'b0;
            if (xfer && ready && !hold_read)
                oe <= 1'b1;
            else if (err_clear)
                oe <= 1'b0;
        end
    end

    // Break detect: raised with the null character, dropped on return to mark.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)
            brk <= 1'b0;
        else if (brk_set)
            brk <= 1'b1;
        else if (brk_clr)
            brk <= 1'b0;
    end

    // R8: overrun only appears when an unread character was present.
    assert_overrun_needs_unread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(ready));

    // R2: a disable leaves ready and all error flags cleared.
    assert_flush_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!ready && !pe && !fe && !oe && !brk));

    // R10: break detect rises together with an all-zero, framed-bad character.
    assert_break_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk) |-> (hold_data == '0 && fe && ready));
endmodule

// File: rtl/async_break_rx.sv
// Asynchronous receiver: start validation, data/parity/stop sampling, break handling.
// Assumes: rx_tick is a one-clock pulse at 1X/16X/64X the bit rate, rx_line is
// already synchronised to clk, and mode inputs are static during a character.
module async_break_rx
    import async_break_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FACTOR_MID = 16,
    parameter int FACTOR_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_tick,
    input  logic              rx_line,
    input  logic              carrier_n,
    input  logic              rx_enable,
    input  logic [1:0]        clk_factor,
    input  logic [1:0]        char_len,
    input  logic              parity_on,
    input  logic              parity_even,
    input  logic              hold_read,
    input  logic              err_clear,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              parity_err,
    output logic              frame_err,
    output logic              overrun_err,
    output logic              break_det
);
    localparam int CNT_W = $clog2(FACTOR_HI);

    rx_state_e         state, state_n;
    logic              tick_q, sample, one_x;
    logic [CNT_W-1:0]  full_m1, half_m1, cnt_val;
    logic              cnt_load, cnt_expired;
    logic              sh_clr, sh_shift, sh_last, sh_par, sh_any;
    logic [DATA_W-1:0] sh_data;
    logic              par_cap, par_bit;
    logic              xfer, brk_set, brk_clr, is_break, xfer_pe, flush;

    assign tick_q = rx_tick & ~carrier_n;
    assign sample = tick_q & cnt_expired;
    assign flush  = ~rx_enable;

    // Reload values for one bit time and half a bit time, per clock factor.
    always_comb begin
        case (fac_e'(clk_factor))
            FAC_1X: begin
                full_m1 = '0;
                half_m1 = '0;
                one_x   = 1'b1;
            end
            FAC_16X: begin
                full_m1 = CNT_W'(FACTOR_MID - 1);
                half_m1 = CNT_W'(FACTOR_MID / 2 - 1);
                one_x   = 1'b0;
            end
            default: begin
                full_m1 = CNT_W'(FACTOR_HI - 1);
                half_m1 = CNT_W'(FACTOR_HI / 2 - 1);
                one_x   = 1'b0;
            end
        endcase
    end

    assign is_break = ~sh_any & ~par_bit & ~rx_line;
    assign xfer_pe  = parity_on & ~is_break & (sh_par ^ par_bit ^ ~parity_even);

    // Next-state and control strobes for the frame sequencer.
    always_comb begin
        state_n  = state;
        cnt_load = 1'b0;
        cnt_val  = full_m1;
        sh_clr   = 1'b0;
        sh_shift = 1'b0;
        par_cap  = 1'b0;
        xfer     = 1'b0;
        brk_set  = 1'b0;
        brk_clr  = 1'b0;
        if (!rx_enable) begin
            state_n = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: state_n = ST_ARM;
                ST_ARM: if (tick_q) state_n = ST_HUNT;
                ST_HUNT: if (tick_q && !rx_line) begin
                    sh_clr   = 1'b1;
                    cnt_load = 1'b1;
                    if (one_x) begin
                        state_n = ST_DATA;
                        cnt_val = full_m1;
                    end else begin
                        state_n = ST_START;
                        cnt_val = half_m1;
                    end
                end
                ST_START: if (sample) begin
                    if (rx_line) begin
                        state_n = ST_HUNT;
                    end else begin
                        state_n  = ST_DATA;
                        cnt_load = 1'b1;
                    end
                end
                ST_DATA: if (sample) begin
                    sh_shift = 1'b1;
                    cnt_load = 1'b1;
                    if (sh_last)
                        state_n = parity_on ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (sample) begin
                    par_cap  = 1'b1;
                    cnt_load = 1'b1;
                    state_n  = ST_STOP;
                end
                ST_STOP: if (sample) begin
                    xfer = 1'b1;
                    if (is_break) begin
                        brk_set = 1'b1;
                        state_n = ST_BREAK;
                    end else if (rx_line) begin
                        state_n = ST_HUNT;
                    end else begin
                        state_n  = ST_START;
                        sh_clr   = 1'b1;
                        cnt_load = 1'b1;
                    end
                end
                ST_BREAK: if (tick_q && rx_line) begin
                    brk_clr = 1'b1;
                    state_n = ST_HUNT;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Captured parity bit for the current character.
    always_ff @(posedge clk) begin
        if (!rst_n || sh_clr)
            par_bit <= 1'b0;
        else if (par_cap)
            par_bit <= rx_line;
    end

    brk_rx_bitclock #(.CNT_W(CNT_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (tick_q),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    brk_rx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .shift    (sh_shift),
        .bit_in   (rx_line),
        .len_code (char_len),
        .data     (sh_data),
        .last     (sh_last),
        .par_acc  (sh_par),
        .any_one  (sh_any)
    );

    brk_rx_status #(.DATA_W(DATA_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .xfer      (xfer),
        .xfer_data (sh_data),
        .xfer_pe   (xfer_pe),
        .xfer_fe   (~rx_line),
        .brk_set   (brk_set),
        .brk_clr   (brk_clr),
        .hold_read (hold_read),
        .err_clear (err_clear),
        .hold_data (rx_data),
        .ready     (rx_ready),
        .pe        (parity_err),
        .fe        (frame_err),
        .oe        (overrun_err),
        .brk       (break_det)
    );

    // R3: with the carrier absent the sequencer does not move.
    assert_carrier_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_n && rx_enable && state != ST_IDLE) |=> $stable(state));

    // R4: a start bit is only confirmed when the recheck saw a low line.
    assert_start_recheck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_START && state == ST_DATA) |-> !$past(rx_line));

    // R2: the arming tick never starts a character.
    assert_arm_skips_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> (state != ST_START && state != ST_DATA));
endmodule

// File: tb/sim_async_break_rx.sv
// Bench: behavioural reference model compared with the design on every clock.
module sim_async_break_rx;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rx_tick = 1'b0, rx_line = 1'b1, carrier_n = 1'b0, rx_enable = 1'b0;
    logic [1:0] clk_factor = 2'd0, char_len = 2'd0;
    logic       parity_on = 1'b0, parity_even = 1'b0, hold_read = 1'b0, err_clear = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, frame_err, overrun_err, break_det;

    int checks = 0, failures = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    async_break_rx u0 (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
        .carrier_n(carrier_n), .rx_enable(rx_enable), .clk_factor(clk_factor),
        .char_len(char_len), .parity_on(parity_on), .parity_even(parity_even),
        .hold_read(hold_read), .err_clear(err_clear), .rx_data(rx_data),
        .rx_ready(rx_ready), .parity_err(parity_err), .frame_err(frame_err),
        .overrun_err(overrun_err), .break_det(break_det)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
        end
    endtask

    // Reference model state.
    int         m_mode = 0, m_since = 0;
    bit         m_chk = 1'b0;
    bit         mq[$];
    logic [7:0] m_data = 8'h00;
    bit         m_rdy = 0, m_pe = 0, m_fe = 0, m_oe = 0, m_brk = 0;

    function automatic int fac_of(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 16 : 64;
    endfunction

    always @(posedge clk) begin
        int f, off, nb, len;
        bit tk, rprev, any1, stp, brk, x, p;
        logic [7:0] d;
        if (!rst_n) begin
            m_mode = 0; m_data = 8'h00;
            m_rdy = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_brk = 0;
        end else if (!rx_enable) begin
            m_mode = 0;
            m_rdy = 0; m_pe = 0; m_fe = 0; m_oe = 0; m_brk = 0;
        end else begin
            f = fac_of(clk_factor);
            off = (f == 1) ? 0 : f / 2;
            len = 5 + int'(char_len);
            nb = len + (parity_on ? 1 : 0) + 1;
            tk = rx_tick && !carrier_n;
            rprev = m_rdy;
            if (err_clear) begin m_pe = 0; m_fe = 0; m_oe = 0; end
            if (hold_read) m_rdy = 0;
            case (m_mode)
                0: m_mode = 1;
                1: if (tk) m_mode = 2;
                2: if (tk && !rx_line) begin
                    m_mode = 3; m_since = 0; m_chk = 0; mq.delete();
                end
                3: if (tk) begin
                    m_since++;
                    if (m_since == off && (f > 1 || m_chk)) begin
                        if (rx_line) m_mode = 2;
                    end else if (m_since > off && ((m_since - off) % f) == 0) begin
                        mq.push_back(rx_line);
                        if (mq.size() == nb) begin
                            d = 8'h00; x = 0; any1 = 0;
                            for (int i = 0; i < len; i++) begin
                                d[i] = mq[i]; x ^= mq[i]; any1 |= mq[i];
                            end
                            p = parity_on ? mq[len] : 1'b0;
                            any1 |= p;
                            stp = mq[nb-1];
                            brk = !any1 && !stp;
                            m_data = d;
                            if (rprev && !hold_read) m_oe = 1;
                            m_rdy = 1;
                            if (!brk && parity_on && (x ^ p ^ !parity_even)) m_pe = 1;
                            if (!stp) m_fe = 1;
                            if (brk) begin m_brk = 1; m_mode = 4; end
                            else if (stp) m_mode = 2;
                            else begin m_since = off - f; m_chk = 1; mq.delete(); end
                        end
                    end
                end
                4: if (tk && rx_line) begin m_brk = 0; m_mode = 2; end
                default: m_mode = 0;
            endcase
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R5 rx_data", {24'h0, rx_data}, {24'h0, m_data});
            chk("R7 rx_ready", {31'h0, rx_ready}, {31'h0, m_rdy});
            chk("R6 parity_err", {31'h0, parity_err}, {31'h0, m_pe});
            chk("R9 frame_err", {31'h0, frame_err}, {31'h0, m_fe});
            chk("R8 overrun_err", {31'h0, overrun_err}, {31'h0, m_oe});
            chk("R10 break_det", {31'h0, break_det}, {31'h0, m_brk});
        end
    end

    // Receive tick: one clock in three.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            rx_tick = (k == 2);
            k = (k + 1) % 3;
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (rx_tick !== 1'b1);
        end
        @(negedge clk);
    endtask

    task automatic send_sym(input logic v, input int n);
        rx_line = v;
        wait_ticks(n);
    endtask

    task automatic send_char(input int f, input int len, input logic [7:0] d,
                             input bit pon, input bit pev, input bit stop, input bit badpar);
        bit x = 0;
        send_sym(1'b0, f);
        for (int i = 0; i < len; i++) begin
            send_sym(d[i], f);
            x ^= d[i];
        end
        if (pon) send_sym(x ^ !pev ^ badpar, f);
        send_sym(stop, f);
    endtask

    task automatic configure(input logic [1:0] fc, input logic [1:0] cl, input bit pon, input bit pev);
        rx_enable = 1'b0;
        @(negedge clk);
        clk_factor = fc; char_len = cl; parity_on = pon; parity_even = pev;
        rx_line = 1'b1;
        @(negedge clk);
        rx_enable = 1'b1;
        wait_ticks(3);
    endtask

    task automatic pulse_read();
        hold_read = 1'b1; @(negedge clk); hold_read = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_clear();
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rx_data", {24'h0, rx_data}, 32'h0);
        chk("R1 reset rx_ready", {31'h0, rx_ready}, 32'h0);
        chk("R1 reset parity_err", {31'h0, parity_err}, 32'h0);
        chk("R1 reset frame_err", {31'h0, frame_err}, 32'h0);
        chk("R1 reset overrun_err", {31'h0, overrun_err}, 32'h0);
        chk("R1 reset break_det", {31'h0, break_det}, 32'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // 16X, 8 data bits, no parity
        configure(2'd1, 2'd3, 1'b0, 1'b0);
        send_sym(1'b1, 32);
        send_char(16, 8, 8'hA5, 0, 0, 1, 0);
        send_sym(1'b1, 32);
        chk("R5 16X byte", {24'h0, rx_data}, 32'hA5);
        chk("R7 ready after stop", {31'h0, rx_ready}, 32'h1);
        pulse_read();
        chk("R7 ready cleared by read", {31'h0, rx_ready}, 32'h0);

        // False start: low for fewer than half a bit
        send_sym(1'b0, 4);
        send_sym(1'b1, 64);
        chk("R4 false start ignored", {31'h0, rx_ready}, 32'h0);
        send_char(16, 8, 8'h3C, 0, 0, 1, 0);
        send_sym(1'b1, 32);
        chk("R4 valid start after glitch", {24'h0, rx_data}, 32'h3C);

        // Overrun, then error clear
        send_char(16, 8, 8'h81, 0, 0, 1, 0);
        send_sym(1'b1, 32);
        chk("R8 overrun on unread", {31'h0, overrun_err}, 32'h1);
        pulse_clear();
        chk("R11 overrun cleared", {31'h0, overrun_err}, 32'h0);
        pulse_read();

        // Framing error with a space that continues as the next start bit
        send_char(16, 8, 8'h3C, 0, 0, 0, 0);
        send_char(16, 8, 8'h5A, 0, 0, 1, 0);
        send_sym(1'b1, 32);
        chk("R9 framing error flagged", {31'h0, frame_err}, 32'h1);
        chk("R9 next char after missing stop", {24'h0, rx_data}, 32'h5A);
        pulse_clear();
        pulse_read();
        chk("R11 frame flag cleared", {31'h0, frame_err}, 32'h0);

        // Break: line low for twelve bit times
        send_sym(1'b0, 16 * 12);
        chk("R10 break detect high", {31'h0, break_det}, 32'h1);
        chk("R10 break null char", {24'h0, rx_data}, 32'h0);
        chk("R10 break framing flag", {31'h0, frame_err}, 32'h1);
        chk("R10 single char only", {31'h0, overrun_err}, 32'h0);
        send_sym(1'b1, 32);
        chk("R10 break detect cleared at mark", {31'h0, break_det}, 32'h0);
        pulse_read();
        pulse_clear();

        // Carrier absent: a whole frame has no effect
        carrier_n = 1'b1;
        send_char(16, 8, 8'h55, 0, 0, 1, 0);
        send_sym(1'b1, 16);
        carrier_n = 1'b0;
        send_sym(1'b1, 32);
        chk("R3 no char while carrier absent", {31'h0, rx_ready}, 32'h0);

        // Disable clears ready
        send_char(16, 8, 8'h11, 0, 0, 1, 0);
        send_sym(1'b1, 32);
        chk("R2 char before disable", {31'h0, rx_ready}, 32'h1);
        rx_enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 ready cleared by disable", {31'h0, rx_ready}, 32'h0);

        // 1X, 5 bits, even parity
        configure(2'd0, 2'd0, 1'b1, 1'b1);
        send_sym(1'b1, 4);
        send_char(1, 5, 8'h13, 1, 1, 1, 0);
        send_sym(1'b1, 4);
        chk("R12 1X five-bit char", {24'h0, rx_data}, 32'h13);
        chk("R6 even parity accepted", {31'h0, parity_err}, 32'h0);

        // 64X, 7 bits, odd parity with a wrong parity bit
        configure(2'd2, 2'd2, 1'b1, 1'b0);
        send_sym(1'b1, 128);
        send_char(64, 7, 8'h4B, 1, 0, 1, 1);
        send_sym(1'b1, 128);
        chk("R12 64X seven-bit char", {24'h0, rx_data}, 32'h4B);
        chk("R6 odd parity mismatch", {31'h0, parity_err}, 32'h1);

        finish_run();
    end
endmodule